// File: doc/BRIEF.md
# DAC Serial Frame Transmitter

This block is the controller-side master that loads a single-channel voltage-output DAC over a three-wire serial link: an active-low chip-select/load line, a serial clock and a serial data line. A client hands over one request made of a 4-bit command, a resolution code, the DAC code value and a flag that selects the long frame. The block then builds the frame, clocks it out MSB first and pulses a done output when chip-select returns high. Chip-select going high is the moment the DAC runs the command.

The frame carries the command nibble first. Four zero pad bits follow, then a 16-bit data field holding the code left-justified, with zeros below it. In long mode eight zero bits go out ahead of that 24-bit core, which suits hosts that move data in whole bytes. Data changes only while the serial clock is low, so each rising edge samples a settled bit. Every timing margin is a count of system-clock cycles set by a parameter: the clock high and low phases, the delay from chip-select falling to the first rising edge, the delay from the last rising edge to chip-select rising, and the minimum time chip-select stays high between frames.

A one-entry holding register takes a new request while a frame is still going out, so a client can queue the next write. A ready/valid handshake refuses any further request until that entry has been taken.

Top module: `dacf_tx`

## Requirements
- R1: A short frame (req_wide=0) has exactly 24 rising serial-clock edges. The bits sampled on them are, in order: req_cmd bit 3 down to bit 0, four 0 bits, then a 16-bit field holding the code left-justified (code MSB first), with 0 in the positions below the code.
- R2: A long frame (req_wide=1) has exactly 32 rising edges. The first 8 sampled bits are 0, and the remaining 24 are the R1 sequence.
- R3: req_res selects the code width: 2'b00 is 8 bits, 2'b01 is 10 bits, 2'b10 and 2'b11 are 12 bits. The code is the low bits of req_code. Any req_code bit above the selected width is never transmitted.
- R4: Out of reset, and whenever dac_sel_n is high, dac_sclk and dac_sdata are 0. After reset dac_sel_n=1, busy=0, done=0 and req_ready=1.
- R5: Every high phase and every low phase of dac_sclk inside a frame lasts exactly HALF_CYC clock cycles. The phase before the first rising edge is excluded.
- R6: dac_sdata changes only in cycles where dac_sclk is low. It is never updated in the cycle of a rising edge or while the clock is high.
- R7: The first rising edge follows the fall of dac_sel_n by at least LEAD_CYC cycles. dac_sel_n rises at least LAG_CYC cycles after the last rising edge, and dac_sclk is low by then.
- R8: Between two frames dac_sel_n stays high for at least GAP_CYC cycles.
- R9: done is a single-cycle pulse, raised in exactly the cycle in which dac_sel_n rises, once per frame.
- R10: busy is high from the cycle after a request is accepted until the done of its frame. While a frame is in flight, one more request is accepted into the holding register. req_ready then stays low until the engine takes that entry. The held request is sent next, and busy stays high through the first frame's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_cmd | input | 4 | Command nibble sent first in the frame |
| req_res | input | 2 | Code width select (00: 8, 01: 10, 1x: 12 bits) |
| req_code | input | CODE_W | Code value, right-aligned |
| req_wide | input | 1 | 1 selects the 32-bit frame with 8 leading zeros |
| busy | output | 1 | A request is held or a frame is in progress |
| done | output | 1 | One-cycle pulse when chip-select returns high |
| dac_sel_n | output | 1 | Chip-select/load to the DAC, active low |
| dac_sclk | output | 1 | Serial clock to the DAC, idles low |
| dac_sdata | output | 1 | Serial data to the DAC, idles low |

## Verification
The checker assumes that the request fields stay steady while req_valid is high and req_ready is low. It also assumes that the timing parameters are small enough for its saturating phase counters. The bench changes the request fields only on falling clock edges, while req_valid is high, and holds them until the accepting edge has passed. It keeps the default timing counts, so the saturating counters never reach their limit. Because the bench never drives reset in the middle of a frame, the properties only ever see frames that started cleanly.

// File: rtl/dacf_pkg.sv
package dacf_pkg;

   localparam int CMD_W   = 4;
   localparam int PAD_W   = 4;
   localparam int FIELD_W = 16;
   localparam int PRE_W   = 8;
   localparam int CORE_W  = CMD_W + PAD_W + FIELD_W;
   localparam int FRAME_W = CORE_W + PRE_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_LAG,
      ST_GAP
   } seq_st_e;

   typedef struct packed {
      logic [CMD_W-1:0]   cmd;
      logic [1:0]         res;
      logic [FIELD_W-1:0] code;
      logic               wide;
   } dacf_req_t;

   function automatic int res_bits(input logic [1:0] sel);
      case (sel)
         2'b00:   return 8;
         2'b01:   return 10;
         default: return 12;
      endcase
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/dacf_req_hold.sv
module dacf_req_hold
   import dacf_pkg::*;
#(
   parameter bit HOLD_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      in_valid,
   output logic      in_ready,
   input  dacf_req_t in_req,
   output logic      out_valid,
   output dacf_req_t out_req,
   input  logic      out_take,
   output logic      holding
);

   generate
      if (HOLD_EN) begin : g_reg
         logic      full_q;
         dacf_req_t req_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               req_q  <= '0;
            end else begin
               if (out_take) full_q <= 1'b0;
               if (in_valid && in_ready) begin
                  full_q <= 1'b1;
                  req_q  <= in_req;
               end
            end
         end

         assign in_ready  = !full_q;
         assign out_valid = full_q;
         assign out_req   = req_q;
         assign holding   = full_q;
      end else begin : g_pass
         assign in_ready  = out_take;
         assign out_valid = in_valid;
         assign out_req   = in_req;
         assign holding   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dacf_frame_pack.sv
module dacf_frame_pack
   import dacf_pkg::*;
(
   input  dacf_req_t           req,
   output logic [FRAME_W-1:0]  word,
   output logic [CNT_W-1:0]    nbits
);

   logic [FIELD_W-1:0] data_lj;
   logic [4:0]         shamt;
   logic [CORE_W-1:0]  core;

   always_comb begin
      shamt   = 5'(FIELD_W - res_bits(req.res));
      data_lj = req.code << shamt;
      core    = {req.cmd, {PAD_W{1'b0}}, data_lj};
      if (req.wide) begin
         word  = {{PRE_W{1'b0}}, core};
         nbits = CNT_W'(FRAME_W);
      end else begin
         word  = {core, {PRE_W{1'b0}}};
         nbits = CNT_W'(CORE_W);
      end
   end

endmodule

// File: rtl/dacf_seq.sv
module dacf_seq
   import dacf_pkg::*;
#(
   parameter int HALF_CYC = 2,
   parameter int LEAD_CYC = 2,
   parameter int LAG_CYC  = 2,
   parameter int GAP_CYC  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_valid,
   input  logic [FRAME_W-1:0] start_word,
   input  logic [CNT_W-1:0]   start_bits,
   output logic               take,
   output logic               engine_busy,
   output logic               ser_sel_n,
   output logic               ser_sclk,
   output logic               ser_sdata,
   output logic               frame_done
);

   localparam int MAX_T = max4(HALF_CYC, LEAD_CYC, LAG_CYC, GAP_CYC);
   localparam int TMR_W = $clog2(MAX_T + 1);
   localparam logic [TMR_W-1:0] T_HALF = TMR_W'(HALF_CYC - 1);
   localparam logic [TMR_W-1:0] T_LEAD = TMR_W'(LEAD_CYC - 1);
   localparam logic [TMR_W-1:0] T_LAG  = TMR_W'(LAG_CYC - 1);
   localparam logic [TMR_W-1:0] T_GAP  = TMR_W'(GAP_CYC - 1);

   seq_st_e            st_q;
   logic [TMR_W-1:0]   tmr_q;
   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   bits_q;
   logic               sel_n_q, sclk_q, sd_q, done_q;
   logic               tmr_zero;

   assign tmr_zero    = (tmr_q == '0);
   assign take        = (st_q == ST_IDLE) && start_valid;
   assign engine_busy = (st_q == ST_LEAD) || (st_q == ST_HIGH) ||
                        (st_q == ST_LOW)  || (st_q == ST_LAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         tmr_q   <= '0;
         sh_q    <= '0;
         bits_q  <= '0;
         sel_n_q <= 1'b1;
         sclk_q  <= 1'b0;
         sd_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_valid) begin
                  sel_n_q <= 1'b0;
                  sd_q    <= start_word[FRAME_W-1];
                  sh_q    <= start_word << 1;
                  bits_q  <= start_bits;
                  tmr_q   <= T_LEAD;
                  st_q    <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tmr_zero) begin
                  sclk_q <= 1'b1;
                  bits_q <= bits_q - 1'b1;
                  tmr_q  <= T_HALF;
                  st_q   <= ST_HIGH;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            ST_HIGH: begin
               if (tmr_zero) begin
                  sclk_q <= 1'b0;
                  if (bits_q == '0) begin
                     sd_q  <= 1'b0;
                     tmr_q <= T_LAG;
                     st_q  <= ST_LAG;
                  end else begin
                     sd_q  <= sh_q[FRAME_W-1];
                     sh_q  <= sh_q << 1;
                     tmr_q <= T_HALF;
                     st_q  <= ST_LOW;
                  end
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            ST_LOW: begin
               if (tmr_zero) begin
                  sclk_q <= 1'b1;
                  bits_q <= bits_q - 1'b1;
                  tmr_q  <= T_HALF;
                  st_q   <= ST_HIGH;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            ST_LAG: begin
               if (tmr_zero) begin
                  sel_n_q <= 1'b1;
                  done_q  <= 1'b1;
                  tmr_q   <= T_GAP;
                  st_q    <= ST_GAP;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            ST_GAP: begin
               if (tmr_zero) st_q <= ST_IDLE;
               else          tmr_q <= tmr_q - 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ser_sel_n  = sel_n_q;
   assign ser_sclk   = sclk_q;
   assign ser_sdata  = sd_q;
   assign frame_done = done_q;

endmodule

// File: rtl/dacf_tx.sv
module dacf_tx
   import dacf_pkg::*;
#(
   parameter int CODE_W   = 12,
   parameter int HALF_CYC = 2,
   parameter int LEAD_CYC = 2,
   parameter int LAG_CYC  = 2,
   parameter int GAP_CYC  = 2,
   parameter bit HOLD_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [3:0]        req_cmd,
   input  logic [1:0]        req_res,
   input  logic [CODE_W-1:0] req_code,
   input  logic              req_wide,
   output logic              busy,
   output logic              done,
   output logic              dac_sel_n,
   output logic              dac_sclk,
   output logic              dac_sdata
);

   generate
      if (CODE_W < 12 || CODE_W > FIELD_W) begin : g_bad_code_w
         $error("dacf_tx: CODE_W must lie between 12 and the data field width");
      end
      if (HALF_CYC < 1 || LEAD_CYC < 1 || LAG_CYC < 1 || GAP_CYC < 1) begin : g_bad_timing
         $error("dacf_tx: every timing count must be at least one cycle");
      end
   endgenerate

   dacf_req_t          in_req, cur_req;
   logic               cur_valid, take, holding, engine_busy;
   logic [FRAME_W-1:0] word;
   logic [CNT_W-1:0]   nbits;

   always_comb begin
      in_req.cmd  = req_cmd;
      in_req.res  = req_res;
      in_req.code = FIELD_W'(req_code);
      in_req.wide = req_wide;
   end

   dacf_req_hold #(.HOLD_EN(HOLD_EN)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_ready  (req_ready),
      .in_req    (in_req),
      .out_valid (cur_valid),
      .out_req   (cur_req),
      .out_take  (take),
      .holding   (holding)
   );

   dacf_frame_pack u_pack (
      .req   (cur_req),
      .word  (word),
      .nbits (nbits)
   );

   dacf_seq #(
      .HALF_CYC (HALF_CYC),
      .LEAD_CYC (LEAD_CYC),
      .LAG_CYC  (LAG_CYC),
      .GAP_CYC  (GAP_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_valid (cur_valid),
      .start_word  (word),
      .start_bits  (nbits),
      .take        (take),
      .engine_busy (engine_busy),
      .ser_sel_n   (dac_sel_n),
      .ser_sclk    (dac_sclk),
      .ser_sdata   (dac_sdata),
      .frame_done  (done)
   );

   assign busy = holding || engine_busy;

endmodule

// File: rtl/dacf_tx_chk.sv
module dacf_tx_chk #(
   parameter int HALF_CYC = 2,
   parameter int LAG_CYC  = 2
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic sel_n,
   input logic sclk,
   input logic sdata
);

   logic [15:0] hi_cnt, since_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt     <= '0;
         since_rise <= 16'hFFFF;
      end else begin
         if (!sclk)                hi_cnt <= '0;
         else if (hi_cnt != '1)    hi_cnt <= hi_cnt + 1'b1;
         if (sclk && hi_cnt == '0) since_rise <= '0;
         else if (since_rise != '1) since_rise <= since_rise + 1'b1;
      end
   end

   // R4: clock and data idle low while deselected
   p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |-> (!sclk && !sdata));

   // R5: high phase length
   p_high_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_cnt == 16'(HALF_CYC)));

   // R6: data held while clock high
   p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdata));

   // R7: lag between last rising edge and deselect
   p_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |-> (since_rise >= 16'(LAG_CYC)));

   // R9: done coincides with deselect
   p_done_at_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |-> done);

   p_done_only_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(sel_n));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: busy covers the frame up to its done
   p_busy_before_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |-> $past(busy));

endmodule

bind dacf_tx dacf_tx_chk #(
   .HALF_CYC (HALF_CYC),
   .LAG_CYC  (LAG_CYC)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy),
   .done  (done),
   .sel_n (dac_sel_n),
   .sclk  (dac_sclk),
   .sdata (dac_sdata)
);

// File: tb/dacf_tx_bench.sv
`timescale 1ns/1ps
module dacf_tx_bench;

   localparam int HALF = 2;
   localparam int LEAD = 2;
   localparam int LAG  = 2;
   localparam int GAP  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_cmd = '0;
   logic [1:0]  req_res = '0;
   logic [11:0] req_code = '0;
   logic        req_wide = 1'b0;
   logic        dac_busy, dac_done, dac_sel_n, dac_sclk, dac_sdata;

   int errs = 0;
   int checks = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   dacf_tx #(
      .CODE_W(12), .HALF_CYC(HALF), .LEAD_CYC(LEAD),
      .LAG_CYC(LAG), .GAP_CYC(GAP), .HOLD_EN(1'b1)
   ) u_dacf_tx (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_cmd(req_cmd), .req_res(req_res), .req_code(req_code), .req_wide(req_wide),
      .busy(dac_busy), .done(dac_done), .dac_sel_n(dac_sel_n),
      .dac_sclk(dac_sclk), .dac_sdata(dac_sdata)
   );

   // ---------------- monitor ----------------
   logic [31:0] fr_word [0:15];
   int          fr_bits [0:15];
   logic        done_busy [0:15];
   int frame_cnt = 0, n_done = 0, n_rises = 0;
   int v_idle = 0, v_data = 0, v_phase = 0, v_lead = 0, v_lag = 0, v_gap = 0, v_done = 0;
   int lead_run = 0, hi_run = 0, lo_run = 0, since_rise = 0, gap_run = 0, nb = 0;
   logic first_rise = 1'b0, seen_frame = 1'b0;
   logic [31:0] cap = '1;
   logic p_sel = 1'b1, p_sclk = 1'b0, p_sd = 1'b0;

   always @(negedge clk) begin
      logic rise, fall, cs_fall, cs_rise;
      if (!rst_n) begin
         p_sel = 1'b1; p_sclk = 1'b0; p_sd = 1'b0;
      end else begin
         rise    = dac_sclk && !p_sclk;
         fall    = !dac_sclk && p_sclk;
         cs_fall = !dac_sel_n && p_sel;
         cs_rise = dac_sel_n && !p_sel;
         if (dac_sel_n && (dac_sclk || dac_sdata)) v_idle++;
         if (dac_sclk && (dac_sdata != p_sd)) v_data++;
         if (cs_fall) begin
            if (seen_frame && gap_run < GAP) v_gap++;
            lead_run = 1; first_rise = 1'b1; cap = '1; nb = 0;
         end else if (!dac_sel_n && first_rise && !rise) begin
            lead_run++;
         end
         if (rise) begin
            if (first_rise) begin
               if (lead_run < LEAD) v_lead++;
               first_rise = 1'b0;
            end else if (lo_run != HALF) begin
               v_phase++;
            end
            hi_run = 1; since_rise = 0;
            cap = {cap[30:0], dac_sdata}; nb++; n_rises++;
         end else begin
            if (dac_sclk) hi_run++;
            since_rise++;
         end
         if (fall) begin
            if (hi_run != HALF) v_phase++;
            lo_run = 1;
         end else if (!dac_sclk) begin
            lo_run++;
         end
         if (cs_rise) begin
            if (since_rise < LAG) v_lag++;
            if (frame_cnt < 16) begin
               fr_word[frame_cnt] = cap;
               fr_bits[frame_cnt] = nb;
            end
            frame_cnt++; seen_frame = 1'b1; gap_run = 1;
         end else if (dac_sel_n) begin
            gap_run++;
         end
         if (dac_done) begin
            if (!cs_rise) v_done++;
            if (n_done < 16) done_busy[n_done] = dac_busy;
            n_done++;
         end
         p_sel = dac_sel_n; p_sclk = dac_sclk; p_sd = dac_sdata;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected captured word: 32-bit register shifted from all-ones, so a
   // short frame leaves 8'hFF above its 24 bits.
   function automatic logic [31:0] exp_frame(input logic [3:0] c, input logic [1:0] r,
                                             input logic [11:0] code, input bit w);
      int n;
      logic [15:0] d;
      logic [23:0] f;
      n = (r == 2'b00) ? 8 : (r == 2'b01) ? 10 : 12;
      d = '0;
      for (int i = 0; i < n; i++) d[15-i] = code[n-1-i];
      f = {c, 4'b0000, d};
      return w ? {8'h00, f} : {8'hFF, f};
   endfunction

   task automatic send(input logic [3:0] c, input logic [1:0] r, input logic [11:0] code, input bit w);
      @(negedge clk);
      req_cmd = c; req_res = r; req_code = code; req_wide = w; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_frames(input int target);
      while (frame_cnt < target) @(negedge clk);
      repeat (GAP + 2) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk(dac_sel_n == 1'b1, "R4 reset sel_n", 32'(dac_sel_n), 32'd1);
      chk(dac_sclk == 1'b0 && dac_sdata == 1'b0, "R4 reset sclk/sdata",
          {30'd0, dac_sclk, dac_sdata}, 32'd0);
      chk(dac_busy == 1'b0 && dac_done == 1'b0, "R4 reset busy/done",
          {30'd0, dac_busy, dac_done}, 32'd0);
      chk(req_ready == 1'b1, "R4 reset ready", 32'(req_ready), 32'd1);
   endtask

   task automatic t_frame(input string req, input logic [3:0] c, input logic [1:0] r,
                          input logic [11:0] code, input bit w);
      int base;
      logic [31:0] e;
      base = frame_cnt;
      e = exp_frame(c, r, code, w);
      send(c, r, code, w);
      chk(dac_busy == 1'b1, "R10 busy after accept", 32'(dac_busy), 32'd1);
      wait_frames(base + 1);
      chk(fr_word[base] == e, req, fr_word[base], e);
      chk(fr_bits[base] == (w ? 32 : 24), {req, " bit count"}, 32'(fr_bits[base]), w ? 32'd32 : 32'd24);
      chk(done_busy[n_done-1] == 1'b0, "R10 busy clear at done", 32'(done_busy[n_done-1]), 32'd0);
   endtask

   task automatic t_back_to_back();
      int base;
      logic [31:0] ea, eb;
      base = frame_cnt;
      ea = exp_frame(4'h3, 2'b10, 12'h5A6, 1'b0);
      eb = exp_frame(4'h0, 2'b01, 12'h1C3, 1'b1);
      send(4'h3, 2'b10, 12'h5A6, 1'b0);
      send(4'h0, 2'b01, 12'h1C3, 1'b1);
      chk(req_ready == 1'b0 && dac_busy == 1'b1, "R10 holding full: ready low, busy high",
          {30'd0, req_ready, dac_busy}, 32'd1);
      wait_frames(base + 2);
      chk(fr_word[base] == ea, "R10 first queued frame", fr_word[base], ea);
      chk(fr_word[base+1] == eb, "R10 held frame sent second", fr_word[base+1], eb);
      chk(done_busy[n_done-2] == 1'b1, "R10 busy through first done", 32'(done_busy[n_done-2]), 32'd1);
      chk(done_busy[n_done-1] == 1'b0, "R10 busy low at last done", 32'(done_busy[n_done-1]), 32'd0);
      chk(dac_busy == 1'b0 && req_ready == 1'b1, "R10 idle after queue drains",
          {30'd0, dac_busy, req_ready}, 32'd1);
   endtask

   task automatic t_timing_summary();
      chk(n_rises > 0, "R5 edges observed", 32'(n_rises), 32'd1);
      chk(v_idle == 0, "R4 idle levels while deselected", 32'(v_idle), 32'd0);
      chk(v_phase == 0, "R5 phase lengths", 32'(v_phase), 32'd0);
      chk(v_data == 0, "R6 data changes only while clock low", 32'(v_data), 32'd0);
      chk(v_lead == 0, "R7 lead before first edge", 32'(v_lead), 32'd0);
      chk(v_lag == 0, "R7 lag after last edge", 32'(v_lag), 32'd0);
      chk(v_gap == 0, "R8 deselect gap", 32'(v_gap), 32'd0);
      chk(v_done == 0 && n_done == frame_cnt, "R9 done once per frame at deselect",
          32'(n_done), 32'(frame_cnt));
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc == 50000) begin
         errs++; checks++;
         $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_frame("R1 short frame 12-bit",          4'h3, 2'b10, 12'hA5C, 1'b0);
      t_frame("R1 short frame low code",        4'h4, 2'b10, 12'h001, 1'b0);
      t_frame("R3 10-bit code, upper bits dropped", 4'h0, 2'b01, 12'hEB7, 1'b0);
      t_frame("R2 R3 long frame 8-bit code",    4'hF, 2'b00, 12'h7C3, 1'b1);
      t_frame("R2 R3 long frame res 11 as 12-bit", 4'h6, 2'b11, 12'hFFF, 1'b1);
      t_back_to_back();
      t_timing_summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule